// File: doc/BRIEF.md
# Parity-Checking Bidirectional Bus Transceiver

This block joins two 8-bit buses, called A and B. A direction input chooses which bus drives the other. An active-low enable either lets the selected outputs drive or puts every driven pad into the high-impedance state. The block also holds a parity unit, and a single shared parity pad changes direction together with the data.

When data moves from A to B, the block computes a parity bit from the A data and drives it onto the parity pad. When data moves from B to A, the parity pad becomes an input. The block compares that bit with parity computed from the B data and drives a status output. The status is high when the two agree and low on a mismatch. A select input chooses the parity sense.

Each pad is modelled as separate in, out and output-enable signals, so the design stays synthesizable. The block is purely combinational.

Top module: `xcvr_parity`

## Requirements
- R1: With `dir_a2b`=1 and `oe_n`=0, every bit of `b_oe` is 1, `b_out` equals `a_in`, and every bit of `a_oe` is 0.
- R2: With `dir_a2b`=0 and `oe_n`=0, every bit of `a_oe` is 1, `a_out` equals `b_in`, and every bit of `b_oe` is 0.
- R3: With `oe_n`=1, `a_oe`, `b_oe`, `par_oe` and `chk_oe` are all 0 for any other inputs.
- R4: In A-to-B mode with outputs enabled, `par_oe`=1 and `par_out` equals `odd_sel` XOR the XOR of all bits of `a_in`.
- R5: In B-to-A mode with outputs enabled, `par_oe`=0 and `chk_oe`=1. `chk_out` is 1 when `par_in` equals `odd_sel` XOR the XOR of all bits of `b_in`, and 0 otherwise.
- R6: In A-to-B mode, `chk_oe` is 0 even when the outputs are enabled.
- R7: An all-zero data word counts as an even number of ones. With `odd_sel`=1, the generated parity is 1, and a received parity of 1 gives `chk_out`=1.
- R8: `a_oe` and `b_oe` are never asserted together, and `par_oe` and `chk_oe` are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dir_a2b | input | 1 | 1: A drives B; 0: B drives A |
| oe_n | input | 1 | Active-low enable for all pad drivers |
| odd_sel | input | 1 | Parity sense select |
| a_in | input | 8 | Value seen on the A pads |
| b_in | input | 8 | Value seen on the B pads |
| par_in | input | 1 | Value seen on the parity pad |
| a_out | output | 8 | Value driven onto the A pads |
| a_oe | output | 8 | Driver enables for the A pads |
| b_out | output | 8 | Value driven onto the B pads |
| b_oe | output | 8 | Driver enables for the B pads |
| par_out | output | 1 | Generated parity bit |
| par_oe | output | 1 | Driver enable for the parity pad |
| chk_out | output | 1 | Parity check status, 1 = match |
| chk_oe | output | 1 | Driver enable for the status pad |

## Verification
Every 8-bit data value is applied in both directions, with both parity senses, both received parity values and both enable states. The full sweep covers all even and odd counts of ones, so a wrong parity sense or a missing bit in the XOR tree shows up as a mismatch. The B data is kept different from the A data. This shows whether each destination takes its data from the correct source bus. Separate runs with outputs disabled and with the all-zero word target the high-impedance case and the zero-ones case.

// File: rtl/xcvr_parity.sv
module xcvr_parity #(
  parameter int W = 8
) (
  input  logic         dir_a2b,
  input  logic         oe_n,
  input  logic         odd_sel,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         par_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe,
  output logic         par_out,
  output logic         par_oe,
  output logic         chk_out,
  output logic         chk_oe
);
  logic drive;
  logic tx_en;
  logic rx_en;
  logic rx_par;

  assign drive  = ~oe_n;
  assign tx_en  = drive & dir_a2b;
  assign rx_en  = drive & ~dir_a2b;

  assign b_out  = a_in;
  assign a_out  = b_in;
  assign b_oe   = {W{tx_en}};
  assign a_oe   = {W{rx_en}};

  assign par_out = odd_sel ^ (^a_in);
  assign par_oe  = tx_en;

  assign rx_par  = odd_sel ^ (^b_in);
  assign chk_out = (par_in == rx_par);
  assign chk_oe  = rx_en;

  always_comb begin
    p_no_contention_r8: assert (!((|a_oe) && (|b_oe)));
    p_par_pad_single_r8: assert (!(par_oe && chk_oe));
    p_hiz_r3: assert (!oe_n || (a_oe == '0 && b_oe == '0 && !par_oe && !chk_oe));
    p_chk_off_tx_r6: assert (!dir_a2b || !chk_oe);
    p_a2b_path_r1: assert (!(|b_oe) || b_out == a_in);
    p_b2a_path_r2: assert (!(|a_oe) || a_out == b_in);
  end
endmodule

// File: tb/xcvr_parity_bench.sv
module xcvr_parity_bench;
  localparam int W = 8;

  logic clk = 0;
  always #10 clk = ~clk;

  logic         dir_a2b, oe_n, odd_sel, par_in;
  logic [W-1:0] a_in, b_in;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;
  logic         par_out, par_oe, chk_out, chk_oe;

  int total = 0;
  int bad   = 0;

  xcvr_parity #(.W(W)) u_xcvr_parity (
    .dir_a2b(dir_a2b), .oe_n(oe_n), .odd_sel(odd_sel),
    .a_in(a_in), .b_in(b_in), .par_in(par_in),
    .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe),
    .par_out(par_out), .par_oe(par_oe), .chk_out(chk_out), .chk_oe(chk_oe)
  );

  function automatic logic odd_count(input logic [W-1:0] v);
    int n = 0;
    for (int i = 0; i < W; i++) if (v[i]) n++;
    return (n % 2) == 1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic d, input logic o, input logic s, input logic p,
                       input logic [W-1:0] a, input logic [W-1:0] b);
    @(posedge clk);
    dir_a2b = d; oe_n = o; odd_sel = s; par_in = p; a_in = a; b_in = b;
    #5;
  endtask

  task automatic t_reset_state;
    apply(1'b1, 1'b1, 1'b0, 1'b0, '0, '0);
    chk(a_oe == '0 && b_oe == '0 && !par_oe && !chk_oe, "R3 initial",
        {a_oe, b_oe, 14'b0, par_oe, chk_oe}, 32'h0);
  endtask

  task automatic t_transmit;
    for (int s = 0; s < 2; s++)
      for (int d = 0; d < 256; d++) begin
        logic [W-1:0] a = W'(d);
        logic [W-1:0] b = W'(d) ^ 8'h5A;
        logic exp_par = logic'(s) ^ odd_count(a);
        apply(1'b1, 1'b0, logic'(s), 1'b0, a, b);
        chk(b_oe == '1 && a_oe == '0 && b_out == a, "R1",
            {8'b0, b_oe, a_oe, b_out}, {8'b0, 8'hFF, 8'h00, a});
        chk(par_oe && par_out == exp_par, "R4", {par_oe, par_out}, {1'b1, exp_par});
        chk(!chk_oe, "R6", chk_oe, 0);
        chk(!((|a_oe) && (|b_oe)) && !(par_oe && chk_oe), "R8", {a_oe, b_oe}, 0);
      end
  endtask

  task automatic t_receive;
    for (int s = 0; s < 2; s++)
      for (int p = 0; p < 2; p++)
        for (int d = 0; d < 256; d++) begin
          logic [W-1:0] b = W'(d);
          logic [W-1:0] a = W'(d) ^ 8'hC3;
          logic exp_chk = (logic'(p) == (logic'(s) ^ odd_count(b)));
          apply(1'b0, 1'b0, logic'(s), logic'(p), a, b);
          chk(a_oe == '1 && b_oe == '0 && a_out == b, "R2",
              {8'b0, a_oe, b_oe, a_out}, {8'b0, 8'hFF, 8'h00, b});
          chk(!par_oe && chk_oe && chk_out == exp_chk, "R5",
              {par_oe, chk_oe, chk_out}, {1'b0, 1'b1, exp_chk});
          chk(!((|a_oe) && (|b_oe)), "R8", {a_oe, b_oe}, 0);
        end
  endtask

  task automatic t_disabled;
    for (int m = 0; m < 16; m++)
      for (int d = 0; d < 256; d += 17) begin
        apply(logic'(m[0]), 1'b1, logic'(m[1]), logic'(m[2]), W'(d), W'(d) ^ {W{m[3]}});
        chk(a_oe == '0 && b_oe == '0 && !par_oe && !chk_oe, "R3",
            {a_oe, b_oe, 14'b0, par_oe, chk_oe}, 32'h0);
      end
  endtask

  task automatic t_zero_ones;
    apply(1'b1, 1'b0, 1'b1, 1'b0, '0, '0);
    chk(par_out == 1'b1, "R7 gen", par_out, 1);
    apply(1'b1, 1'b0, 1'b0, 1'b0, '0, '0);
    chk(par_out == 1'b0, "R7 gen even", par_out, 0);
    apply(1'b0, 1'b0, 1'b1, 1'b1, '0, '0);
    chk(chk_out == 1'b1 && chk_oe, "R7 chk", {chk_oe, chk_out}, 2'b11);
    apply(1'b0, 1'b0, 1'b1, 1'b0, '0, '0);
    chk(chk_out == 1'b0, "R7 chk mismatch", chk_out, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    dir_a2b = 1'b1; oe_n = 1'b1; odd_sel = 1'b0; par_in = 1'b0; a_in = '0; b_in = '0;
    t_reset_state();
    t_transmit();
    t_receive();
    t_disabled();
    t_zero_ones();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule